// File: doc/BRIEF.md
# I2C Controller Command Sequencer

This block sits between a queue of byte-level commands and an I2C bit-timing engine in controller mode. Each queue entry holds a byte and three flags: begin-condition, end-condition and receive. The sequencer takes one entry at a time and turns it into one or more operations for the engine: a start (or repeated start), a byte write that returns the target's acknowledge bit, a run of byte reads, and a stop. Received bytes go to a receive queue as they arrive.

When the receive flag is set, the byte field is a count of bytes to fetch and is not sent on the bus. During such a run the controller acknowledges every byte except the final one, which it answers with a not-acknowledge. If the end-condition flag is set, the stop follows that final byte. When a written byte is not acknowledged, the sequencer raises a sticky interrupt, sends a stop, and drops queued entries until an entry with the begin-condition flag arrives. It also reports when the command queue is empty and when the queue level falls to a programmed threshold.

The engine takes one operation at a time. `cmd_valid` stays high with a stable operation until the engine pulses `eng_done`. The command queue is seen through its level and head entry, and the sequencer pops it with a one-cycle strobe.

Top module: `i2c_fmt_seq`

## Requirements
- R1: An entry with the begin flag issues operation START (`cmd_op` = 0) and then, with the receive flag clear, operation WRITE (`cmd_op` = 1) carrying the entry's byte. An entry with neither begin nor receive flag issues only the WRITE.
- R2: An entry with the end flag issues operation STOP (`cmd_op` = 3) after the engine completes the entry's last byte operation. Without the flag, no STOP follows.
- R3: An entry with the receive flag issues as many READ operations (`cmd_op` = 2) as its byte field gives. Each completion pushes `eng_rdata` to `rx_data` with a one-cycle `rx_push`, in completion order.
- R4: A completed WRITE that the engine reports as not acknowledged sets `nak_intr`, which stays high until cleared.
- R5: During a read run, `cmd_ack` is 1 for every READ except the last of the run, where it is 0.
- R6: A receive count of 0 fetches 256 bytes.
- R7: `thr_intr` sets in the cycle after `fmt_level` moves from above `fmt_thresh` to at or below it. It stays high until `thr_clr`. A level that never exceeded the threshold does not set it.
- R8: After a not-acknowledge, the next operation is STOP. Queued entries without the begin flag are then popped and produce no operation, until an entry with the begin flag is processed normally.
- R9: A `nak_clr` strobe clears `nak_intr` in the following cycle, unless a new not-acknowledge arrives in the same cycle, in which case the set wins.
- R10: `fmt_empty` is high in the cycle after `fmt_level` is 0 and low in the cycle after it is non-zero. It is high out of reset.
- R11: Only one operation is outstanding at a time. `cmd_op` and `cmd_byte` hold steady while `cmd_valid` is high and `eng_done` has not arrived, and the command queue is never popped while an operation is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_level | input | LVL_W | Entries currently in the command queue |
| fmt_byte | input | 8 | Head entry byte (data, address or read count) |
| fmt_start | input | 1 | Head entry begin-condition flag |
| fmt_stop | input | 1 | Head entry end-condition flag |
| fmt_read | input | 1 | Head entry receive flag |
| fmt_thresh | input | LVL_W | Threshold level for `thr_intr` |
| fmt_pop | output | 1 | Removes the head entry at this edge |
| cmd_valid | output | 1 | An operation is outstanding at the engine |
| cmd_op | output | 2 | Operation: 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_byte | output | 8 | Byte to write for WRITE |
| cmd_ack | output | 1 | Acknowledge to send after a READ byte |
| eng_done | input | 1 | Engine finished the outstanding operation |
| eng_nak | input | 1 | WRITE was not acknowledged (valid with `eng_done`) |
| eng_rdata | input | 8 | Byte received by READ (valid with `eng_done`) |
| rx_push | output | 1 | Push strobe to the receive queue |
| rx_data | output | 8 | Byte pushed to the receive queue |
| nak_intr | output | 1 | Sticky not-acknowledge interrupt |
| nak_clr | input | 1 | Clear strobe for `nak_intr` |
| thr_intr | output | 1 | Sticky queue-threshold interrupt |
| thr_clr | input | 1 | Clear strobe for `thr_intr` |
| fmt_empty | output | 1 | Command queue holds no entries |

## Verification
The bench uses the default queue depth of 8, so `fmt_level` is 4 bits wide and it can fill the queue with several entries at once. That lets the threshold and empty flags cross their edges from real level movement. Because the count field is 8 bits and the run counter is 9 bits, the 256-byte read from a zero count fits within the run time. That case tests the wrap from count 1 to the final not-acknowledged byte over a long run. A model engine refuses one particular address byte, which drives the drop-until-begin path with non-begin entries queued behind the failed write.

// File: rtl/i2c_fmt_seq_pkg.sv
package i2c_fmt_seq_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } seq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WRITE,
        ST_READ,
        ST_STOP
    } seq_state_e;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = BYTE_W + 1;

    typedef struct packed {
        seq_state_e         st;
        logic [BYTE_W-1:0]  byte_v;
        logic               stop;
        logic               read;
        logic [CNT_W-1:0]   cnt;
        logic               drop;
    } seq_regs_t;

endpackage

// File: rtl/i2c_fmt_seq_fsm.sv
module i2c_fmt_seq_fsm
    import i2c_fmt_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_avail,
    input  logic [BYTE_W-1:0] fmt_byte,
    input  logic              fmt_start,
    input  logic              fmt_stop,
    input  logic              fmt_read,
    output logic              fmt_pop,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              cmd_ack,
    input  logic              eng_done,
    input  logic              eng_nak,
    input  logic [BYTE_W-1:0] eng_rdata,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_data,
    output logic              nak_set
);

    seq_regs_t q, d;

    always_comb begin
        d       = q;
        fmt_pop = 1'b0;
        rx_push = 1'b0;
        nak_set = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (fmt_avail) begin
                    fmt_pop = 1'b1;
                    if (!(q.drop && !fmt_start)) begin
                        d.drop   = 1'b0;
                        d.byte_v = fmt_byte;
                        d.stop   = fmt_stop;
                        d.read   = fmt_read;
                        // zero count selects the full 256-byte run
                        d.cnt    = {fmt_byte == '0, fmt_byte};
                        if (fmt_start)     d.st = ST_START;
                        else if (fmt_read) d.st = ST_READ;
                        else               d.st = ST_WRITE;
                    end
                end
            end
            ST_START: begin
                if (eng_done) d.st = q.read ? ST_READ : ST_WRITE;
            end
            ST_WRITE: begin
                if (eng_done) begin
                    if (eng_nak) begin
                        nak_set = 1'b1;
                        d.drop  = 1'b1;
                        d.st    = ST_STOP;
                    end else begin
                        d.st = q.stop ? ST_STOP : ST_IDLE;
                    end
                end
            end
            ST_READ: begin
                if (eng_done) begin
                    rx_push = 1'b1;
                    d.cnt   = q.cnt - 1'b1;
                    if (q.cnt == CNT_W'(1)) d.st = q.stop ? ST_STOP : ST_IDLE;
                end
            end
            ST_STOP: begin
                if (eng_done) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, byte_v: '0, stop: 1'b0, read: 1'b0, cnt: '0, drop: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        cmd_valid = (q.st != ST_IDLE);
        case (q.st)
            ST_START: cmd_op = OP_START;
            ST_READ:  cmd_op = OP_READ;
            ST_STOP:  cmd_op = OP_STOP;
            default:  cmd_op = OP_WRITE;
        endcase
        cmd_byte = q.byte_v;
        cmd_ack  = (q.st == ST_READ) && (q.cnt != CNT_W'(1));
        rx_data  = eng_rdata;
    end

    // R11: operation held steady until the engine completes it
    p_cmd_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !eng_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

    // R11: no pop while an operation is outstanding
    p_no_pop_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_pop |-> !cmd_valid);

    // R6: a read run never sits at a zero remaining count
    p_cnt_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_READ) |-> (q.cnt != '0));

    // R8: a refused write is followed by a stop
    p_stop_after_nak_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRITE && eng_done && eng_nak) |=> (cmd_valid && cmd_op == OP_STOP));

endmodule

// File: rtl/i2c_fmt_seq_status.sv
module i2c_fmt_seq_status #(
    parameter int unsigned LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fmt_level,
    input  logic [LVL_W-1:0] fmt_thresh,
    input  logic             nak_set,
    input  logic             nak_clr,
    input  logic             thr_clr,
    output logic             nak_intr,
    output logic             thr_intr,
    output logic             fmt_empty
);

    typedef struct packed {
        logic             nak;
        logic             thr;
        logic             empty;
        logic [LVL_W-1:0] lvl;
    } stat_regs_t;

    stat_regs_t q, d;
    logic       thr_edge;

    always_comb begin
        d        = q;
        thr_edge = (q.lvl > fmt_thresh) && (fmt_level <= fmt_thresh);
        d.lvl    = fmt_level;
        d.empty  = (fmt_level == '0);
        if (nak_set)      d.nak = 1'b1;
        else if (nak_clr) d.nak = 1'b0;
        if (thr_edge)     d.thr = 1'b1;
        else if (thr_clr) d.thr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{nak: 1'b0, thr: 1'b0, empty: 1'b1, lvl: '0};
        end else begin
            q <= d;
        end
    end

    assign nak_intr  = q.nak;
    assign thr_intr  = q.thr;
    assign fmt_empty = q.empty;

    // R4: interrupt holds without a clear strobe
    p_nak_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nak_intr && !nak_clr) |=> nak_intr);

    // R9: clear without a fresh refusal drops the interrupt
    p_nak_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (nak_clr && !nak_set) |=> !nak_intr);

    // R7: threshold interrupt holds without a clear strobe
    p_thr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_intr && !thr_clr) |=> thr_intr);

    // R10: empty flag follows a zero level one cycle later
    p_empty_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_level == '0) |=> fmt_empty);

endmodule

// File: rtl/i2c_fmt_seq.sv
module i2c_fmt_seq
    import i2c_fmt_seq_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8,
    localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fmt_level,
    input  logic [7:0]       fmt_byte,
    input  logic             fmt_start,
    input  logic             fmt_stop,
    input  logic             fmt_read,
    input  logic [LVL_W-1:0] fmt_thresh,
    output logic             fmt_pop,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [7:0]       cmd_byte,
    output logic             cmd_ack,
    input  logic             eng_done,
    input  logic             eng_nak,
    input  logic [7:0]       eng_rdata,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    output logic             nak_intr,
    input  logic             nak_clr,
    output logic             thr_intr,
    input  logic             thr_clr,
    output logic             fmt_empty
);

    logic nak_set;
    logic fmt_avail;

    assign fmt_avail = (fmt_level != '0);

    i2c_fmt_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_avail (fmt_avail),
        .fmt_byte  (fmt_byte),
        .fmt_start (fmt_start),
        .fmt_stop  (fmt_stop),
        .fmt_read  (fmt_read),
        .fmt_pop   (fmt_pop),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_byte  (cmd_byte),
        .cmd_ack   (cmd_ack),
        .eng_done  (eng_done),
        .eng_nak   (eng_nak),
        .eng_rdata (eng_rdata),
        .rx_push   (rx_push),
        .rx_data   (rx_data),
        .nak_set   (nak_set)
    );

    i2c_fmt_seq_status #(.LVL_W(LVL_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_level  (fmt_level),
        .fmt_thresh (fmt_thresh),
        .nak_set    (nak_set),
        .nak_clr    (nak_clr),
        .thr_clr    (thr_clr),
        .nak_intr   (nak_intr),
        .thr_intr   (thr_intr),
        .fmt_empty  (fmt_empty)
    );

endmodule

// File: tb/i2c_fmt_seq_tb_top.sv
module i2c_fmt_seq_tb_top;

    localparam int LVL_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] fmt_level;
    logic [7:0]       fmt_byte;
    logic             fmt_start, fmt_stop, fmt_read;
    logic [LVL_W-1:0] fmt_thresh = '0;
    logic             fmt_pop;
    logic             cmd_valid;
    logic [1:0]       cmd_op;
    logic [7:0]       cmd_byte;
    logic             cmd_ack;
    logic             eng_done = 1'b0;
    logic             eng_nak = 1'b0;
    logic [7:0]       eng_rdata = '0;
    logic             rx_push;
    logic [7:0]       rx_data;
    logic             nak_intr;
    logic             nak_clr = 1'b0;
    logic             thr_intr;
    logic             thr_clr = 1'b0;
    logic             fmt_empty;

    always #2 clk = ~clk;

    // command queue model
    logic [10:0] qmem [16];
    int          head = 0;
    int          tail = 0;
    assign fmt_level = LVL_W'(tail - head);
    assign fmt_byte  = qmem[head % 16][7:0];
    assign fmt_start = qmem[head % 16][8];
    assign fmt_stop  = qmem[head % 16][9];
    assign fmt_read  = qmem[head % 16][10];
    always @(posedge clk) if (fmt_pop) head <= head + 1;

    // engine model: operation completes after three cycles
    int         ecnt = 0;
    int         n_ops = 0, n_read = 0, n_ack = 0, n_stop = 0, n_push = 0, rx_err = 0;
    logic [1:0] op_log [64];
    logic [7:0] byte_log [64];
    logic [7:0] rd_seq = '0;
    logic [7:0] exp_rx = '0;
    localparam logic [7:0] REFUSED = 8'hF1;

    always @(posedge clk) begin
        if (!rst_n) begin
            eng_done <= 1'b0;
            ecnt     <= 0;
        end else if (eng_done) begin
            eng_done <= 1'b0;
            ecnt     <= 0;
        end else if (cmd_valid) begin
            if (ecnt == 2) begin
                eng_done  <= 1'b1;
                eng_nak   <= (cmd_op == 2'd1) && (cmd_byte == REFUSED);
                eng_rdata <= rd_seq;
                op_log[n_ops % 64]   <= cmd_op;
                byte_log[n_ops % 64] <= cmd_byte;
                n_ops <= n_ops + 1;
                if (cmd_op == 2'd2) begin
                    rd_seq <= rd_seq + 8'd1;
                    n_read <= n_read + 1;
                    if (cmd_ack) n_ack <= n_ack + 1;
                end
                if (cmd_op == 2'd3) n_stop <= n_stop + 1;
            end else begin
                ecnt <= ecnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (rx_push) begin
            if (rx_data != exp_rx) rx_err <= rx_err + 1;
            exp_rx <= exp_rx + 8'd1;
            n_push <= n_push + 1;
        end
    end

    i2c_fmt_seq dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_level(fmt_level), .fmt_byte(fmt_byte),
        .fmt_start(fmt_start), .fmt_stop(fmt_stop), .fmt_read(fmt_read),
        .fmt_thresh(fmt_thresh), .fmt_pop(fmt_pop), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_ack(cmd_ack),
        .eng_done(eng_done), .eng_nak(eng_nak), .eng_rdata(eng_rdata),
        .rx_push(rx_push), .rx_data(rx_data), .nak_intr(nak_intr),
        .nak_clr(nak_clr), .thr_intr(thr_intr), .thr_clr(thr_clr),
        .fmt_empty(fmt_empty)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic push(input logic st, input logic sp, input logic rd, input logic [7:0] b);
        qmem[tail % 16] = {rd, sp, st, b};
        tail = tail + 1;
    endtask

    task automatic wait_quiet();
        int calm = 0;
        int guard = 0;
        while (calm < 4) begin
            @(negedge clk);
            guard++;
            if (fmt_level == 0 && !cmd_valid) calm++; else calm = 0;
            if (guard > 5000) begin
                check("watchdog", 0, 1);
                break;
            end
        end
    endtask

    task automatic pulse_clr(input bit which_nak);
        @(negedge clk);
        if (which_nak) nak_clr = 1'b1; else thr_clr = 1'b1;
        @(negedge clk);
        nak_clr = 1'b0;
        thr_clr = 1'b0;
    endtask

    // read vectors: [17:10] count byte, [9] stop flag, [8:0] expected reads
    localparam logic [17:0] RD_VEC [5] = '{
        {8'd3, 1'b1, 9'd3},
        {8'd1, 1'b1, 9'd1},
        {8'd2, 1'b0, 9'd2},
        {8'd0, 1'b1, 9'd256},
        {8'd7, 1'b1, 9'd7}
    };

    initial begin
        int b_ops, b_read, b_ack, b_stop, b_push, b_err;
        for (int i = 0; i < 16; i++) qmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R11 reset cmd_valid", int'(cmd_valid), 0);
        check("R11 reset fmt_pop", int'(fmt_pop), 0);
        check("R3 reset rx_push", int'(rx_push), 0);
        check("R4 reset nak_intr", int'(nak_intr), 0);
        check("R7 reset thr_intr", int'(thr_intr), 0);
        check("R10 reset fmt_empty", int'(fmt_empty), 1);

        // table of read runs: R3, R5, R2, R6 (zero count row)
        for (int v = 0; v < 5; v++) begin
            b_ops = n_ops; b_read = n_read; b_ack = n_ack;
            b_stop = n_stop; b_push = n_push; b_err = rx_err;
            @(negedge clk);
            push(1'b0, RD_VEC[v][9], 1'b1, RD_VEC[v][17:10]);
            wait_quiet();
            check("R3 R6 read count", n_read - b_read, int'(RD_VEC[v][8:0]));
            check("R3 pushes", n_push - b_push, int'(RD_VEC[v][8:0]));
            check("R3 push data order", rx_err - b_err, 0);
            check("R5 acked reads", n_ack - b_ack, int'(RD_VEC[v][8:0]) - 1);
            check("R2 stop after run", n_stop - b_stop, int'(RD_VEC[v][9]));
        end

        // R1, R2: addressed write of three bytes
        b_ops = n_ops;
        @(negedge clk);
        push(1'b1, 1'b0, 1'b0, 8'h50);
        push(1'b0, 1'b0, 1'b0, 8'h11);
        push(1'b0, 1'b1, 1'b0, 8'h22);
        // R10: registered empty goes low one edge after level rises
        @(negedge clk);
        check("R10 empty low", int'(fmt_empty), 0);
        wait_quiet();
        check("R10 empty high", int'(fmt_empty), 1);
        check("R1 op count", n_ops - b_ops, 5);
        check("R1 first START", int'(op_log[b_ops % 64]), 0);
        check("R1 addr WRITE", int'(op_log[(b_ops + 1) % 64]), 1);
        check("R1 addr byte", int'(byte_log[(b_ops + 1) % 64]), 8'h50);
        check("R1 plain WRITE byte", int'(byte_log[(b_ops + 2) % 64]), 8'h11);
        check("R1 last WRITE byte", int'(byte_log[(b_ops + 3) % 64]), 8'h22);
        check("R2 final STOP", int'(op_log[(b_ops + 4) % 64]), 3);
        check("R4 no nak on acked writes", int'(nak_intr), 0);

        // R4, R8, R9: refused address, queued entries dropped until begin flag
        b_ops = n_ops;
        @(negedge clk);
        push(1'b1, 1'b0, 1'b0, REFUSED);
        push(1'b0, 1'b0, 1'b0, 8'h33);
        push(1'b0, 1'b1, 1'b0, 8'h44);
        push(1'b1, 1'b1, 1'b0, 8'h52);
        wait_quiet();
        check("R8 op count", n_ops - b_ops, 6);
        check("R8 stop after nak", int'(op_log[(b_ops + 2) % 64]), 3);
        check("R8 restart on begin", int'(op_log[(b_ops + 3) % 64]), 0);
        check("R8 dropped bytes skipped", int'(byte_log[(b_ops + 4) % 64]), 8'h52);
        check("R8 final STOP", int'(op_log[(b_ops + 5) % 64]), 3);
        check("R4 nak set", int'(nak_intr), 1);
        repeat (5) @(negedge clk);
        check("R4 nak sticky", int'(nak_intr), 1);
        pulse_clr(1'b1);
        check("R9 nak cleared", int'(nak_intr), 0);

        // R7: threshold crossing
        fmt_thresh = 4'd1;
        pulse_clr(1'b0);
        check("R7 thr cleared", int'(thr_intr), 0);
        push(1'b0, 1'b0, 1'b0, 8'h01);
        push(1'b0, 1'b0, 1'b0, 8'h02);
        push(1'b0, 1'b0, 1'b0, 8'h03);
        wait_quiet();
        check("R7 thr set on fall", int'(thr_intr), 1);
        pulse_clr(1'b0);
        check("R7 thr clear strobe", int'(thr_intr), 0);
        push(1'b0, 1'b0, 1'b0, 8'h04);
        wait_quiet();
        check("R7 no set below threshold", int'(thr_intr), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule